// File: doc/BRIEF.md
# Host port interrupt vector generator

This block sits on the processor side of a host interface port. It holds the control byte that enables the port's interrupt sources, plus a second byte that enables the six memory-access requests. It turns pending status flags into one vectored interrupt request. Nine sources compete for the request: receive full, transmit empty, six memory read/write requests (X, Y and P spaces) and a host command. Each source counts only while its own enable bit is set. The winning source's vector is captured and held on `irq_vec` until the interrupt controller pulses `irq_ack`.

The eight fixed sources have vectors spaced two apart. The port-select input picks which of two tables is used. The host command vector is not fixed: it is twice an index that the host writes. Two general-purpose flag bits in the control byte are driven out for the host to read. A separate host-side request line is also produced. It is the OR of three host status bits, each gated by its own host enable.

Top module: `hpi_vec_gen`

## Requirements
- R1: After hardware reset, `irq_req`, `host_req` and `dsp_flags` are 0, and `reg_rdata` reads 0 for both `reg_sel` values.
- R2: A write (`reg_we`=1 for one clock) with `reg_sel`=0 loads the control byte. Its bit 0 enables receive full, bit 1 enables transmit empty, bit 2 enables host command, bit 3 drives `dsp_flags[0]`, bit 4 drives `dsp_flags[1]`, and bits 5 to 7 only store data. With `reg_sel`=1 the write loads the memory enable byte. Its bits 0 to 5 enable X read, Y read, P read, X write, Y write and P write. Both bytes read back on `reg_rdata` exactly as written.
- R3: A source is pending only while its status input and its enable bit are both 1. `irq_req` is registered: it rises on the first clock edge after a cycle in which some source is pending, and never rises while every pending source is disabled.
- R4: With `port_sel`=0, the fixed vectors are 0x20 + 2·k. Here k counts 0..7 over receive full, transmit empty, X read, Y read, P read, X write, Y write and P write.
- R5: With `port_sel`=1, the same eight sources use 0x30 + 2·k.
- R6: The host command vector is 2·`cmd_idx`, which spans 0x000 to 0x1FE.
- R7: When several sources are pending together, the one with the smallest k wins. The host command loses to every fixed source.
- R8: While `irq_req` is 1, `irq_vec` stays unchanged and ignores changes on the status inputs, `port_sel` and `cmd_idx`. An `irq_ack` pulse clears `irq_req` at the next edge. One clock later, the block arbitrates again among the sources still pending.
- R9: A synchronous `soft_rst` clears both register bytes, `dsp_flags` and `irq_req` at the next edge.
- R10: `host_req` is registered. It equals the OR, over bits 0..2, of `host_stat` & `host_en` in the previous cycle. The three bits are receive full, transmit empty and transmitter ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| reg_we | input | 1 | Single-cycle register write strobe |
| reg_sel | input | 1 | 0 = control byte, 1 = memory enable byte |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected byte |
| stat_rx_full | input | 1 | Receive full status |
| stat_tx_empty | input | 1 | Transmit empty status |
| stat_mem_req | input | 6 | Memory request status: X rd, Y rd, P rd, X wr, Y wr, P wr |
| stat_cmd_pend | input | 1 | Host command pending status |
| cmd_idx | input | HV_W | Host-written command index |
| port_sel | input | 1 | Vector table select: 0 = A, 1 = B |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | VEC_W | Held vector address |
| dsp_flags | output | 2 | General-purpose flags for the host |
| host_stat | input | N_HOST | Host-side status: rx full, tx empty, tx ready |
| host_en | input | N_HOST | Host-side enables, same order |
| host_req | output | 1 | Registered host request |

## Verification
The bench goes through every source on both tables, every command index, and every one of the 511 nonzero pending patterns. A wrong priority chain or an offset error therefore shows up as a wrong vector. The bench changes `port_sel` and `cmd_idx` while a request is held, to catch a design that builds its vector combinationally instead of capturing it. It also re-acknowledges while a source is still pending, to catch a request that never drops or never re-arms. Finally, it disables each source alone with its status held high: a wrong enable bit shows up as a spurious request.

// File: rtl/hpi_vec_pkg.sv
package hpi_vec_pkg;
   localparam int unsigned NUM_FIXED = 8;
   localparam int unsigned NUM_SRC   = NUM_FIXED + 1;
   localparam int unsigned CMD_SLOT  = NUM_FIXED;
   localparam int unsigned NUM_MEM   = 6;
   localparam int unsigned BASE_A    = 'h20;
   localparam int unsigned BASE_B    = 'h30;
   localparam int unsigned VEC_STEP  = 2;
   localparam int unsigned CTL_BITS  = 8;

   typedef enum logic { SEL_CTL = 1'b0, SEL_MEM = 1'b1 } reg_sel_e;

   typedef struct packed {
      logic [2:0] spare;
      logic       flag3;
      logic       flag2;
      logic       cmd_en;
      logic       tx_en;
      logic       rx_en;
   } ctl_reg_t;
endpackage

// File: rtl/hpi_ctl_regs.sv
module hpi_ctl_regs
   import hpi_vec_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst,
   input  logic                we,
   input  logic                sel,
   input  logic [REG_W-1:0]    wdata,
   output logic [REG_W-1:0]    rdata,
   output logic                rx_en,
   output logic                tx_en,
   output logic                cmd_en,
   output logic [1:0]          flags,
   output logic [NUM_MEM-1:0]  mem_en
);
   ctl_reg_t         ctl_q;
   logic [REG_W-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         mem_q <= '0;
      end else if (soft_rst) begin
         ctl_q <= '0;
         mem_q <= '0;
      end else if (we) begin
         if (sel == SEL_MEM) mem_q <= wdata;
         else                ctl_q <= ctl_reg_t'(wdata);
      end
   end

   assign rdata  = (sel == SEL_MEM) ? mem_q : REG_W'(ctl_q);
   assign rx_en  = ctl_q.rx_en;
   assign tx_en  = ctl_q.tx_en;
   assign cmd_en = ctl_q.cmd_en;
   assign flags  = {ctl_q.flag3, ctl_q.flag2};
   assign mem_en = mem_q[NUM_MEM-1:0];
endmodule

// File: rtl/hpi_src_arb.sv
module hpi_src_arb
   import hpi_vec_pkg::*;
#(
   parameter int unsigned HV_W  = 8,
   parameter int unsigned VEC_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic [NUM_SRC-1:0] pend,
   input  logic               port_sel,
   input  logic [HV_W-1:0]    cmd_idx,
   input  logic               ack,
   output logic               req,
   output logic [VEC_W-1:0]   vec
);
   logic [NUM_SRC:0]   seen;
   logic [NUM_SRC-1:0] win;
   logic [VEC_W-1:0]   nxt_vec;
   int unsigned        base;

   assign seen[0] = 1'b0;
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
      assign win[g]    = pend[g] & ~seen[g];
      assign seen[g+1] = seen[g] | pend[g];
   end

   assign base = port_sel ? BASE_B : BASE_A;

   always_comb begin
      nxt_vec = '0;
      for (int i = 0; i < NUM_FIXED; i++) begin
         if (win[i]) nxt_vec = nxt_vec | VEC_W'(base + VEC_STEP * i);
      end
      if (win[CMD_SLOT]) nxt_vec = nxt_vec | VEC_W'({cmd_idx, 1'b0});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= 1'b0;
         vec <= '0;
      end else if (soft_rst) begin
         req <= 1'b0;
      end else if (req) begin
         if (ack) req <= 1'b0;
      end else if (seen[NUM_SRC]) begin
         req <= 1'b1;
         vec <= nxt_vec;
      end
   end
endmodule

// File: rtl/hpi_host_mask.sv
module hpi_host_mask #(
   parameter int unsigned N_HOST   = 3,
   parameter bit          HOST_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_HOST-1:0] stat,
   input  logic [N_HOST-1:0] en,
   output logic              req
);
   logic any_hit;
   assign any_hit = |(stat & en);

   if (HOST_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req <= 1'b0;
         else        req <= any_hit;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign req = any_hit;
   end
endmodule

// File: rtl/hpi_vec_gen.sv
module hpi_vec_gen
   import hpi_vec_pkg::*;
#(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned HV_W     = 8,
   parameter int unsigned VEC_W    = 16,
   parameter int unsigned N_HOST   = 3,
   parameter bit          HOST_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              stat_rx_full,
   input  logic              stat_tx_empty,
   input  logic [5:0]        stat_mem_req,
   input  logic              stat_cmd_pend,
   input  logic [HV_W-1:0]   cmd_idx,
   input  logic              port_sel,
   input  logic              irq_ack,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec,
   output logic [1:0]        dsp_flags,
   input  logic [N_HOST-1:0] host_stat,
   input  logic [N_HOST-1:0] host_en,
   output logic              host_req
);
   if (REG_W != CTL_BITS) begin : g_chk_reg
      $error("REG_W must match the control byte layout");
   end
   if (VEC_W < HV_W + 1 || VEC_W < 6) begin : g_chk_vec
      $error("VEC_W too narrow for the vector range");
   end
   if (N_HOST < 1) begin : g_chk_host
      $error("N_HOST must be at least 1");
   end

   logic               rx_en, tx_en, cmd_en;
   logic [NUM_MEM-1:0] mem_en;
   logic [NUM_SRC-1:0] pend;

   hpi_ctl_regs #(.REG_W(REG_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .soft_rst(soft_rst),
      .we     (reg_we),
      .sel    (reg_sel),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .rx_en  (rx_en),
      .tx_en  (tx_en),
      .cmd_en (cmd_en),
      .flags  (dsp_flags),
      .mem_en (mem_en)
   );

   assign pend = {stat_cmd_pend & cmd_en,
                  stat_mem_req  & mem_en,
                  stat_tx_empty & tx_en,
                  stat_rx_full  & rx_en};

   hpi_src_arb #(.HV_W(HV_W), .VEC_W(VEC_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .pend    (pend),
      .port_sel(port_sel),
      .cmd_idx (cmd_idx),
      .ack     (irq_ack),
      .req     (irq_req),
      .vec     (irq_vec)
   );

   hpi_host_mask #(.N_HOST(N_HOST), .HOST_REG(HOST_REG)) u_host (
      .clk  (clk),
      .rst_n(rst_n),
      .stat (host_stat),
      .en   (host_en),
      .req  (host_req)
   );
endmodule

// File: rtl/hpi_vec_gen_chk.sv
module hpi_vec_gen_chk #(
   parameter int unsigned HV_W     = 8,
   parameter int unsigned VEC_W    = 16,
   parameter int unsigned N_HOST   = 3,
   parameter int unsigned NSRC     = 9,
   parameter bit          HOST_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic [NSRC-1:0]   pend,
   input logic              irq_req,
   input logic              irq_ack,
   input logic [VEC_W-1:0]  irq_vec,
   input logic [1:0]        dsp_flags,
   input logic [N_HOST-1:0] host_stat,
   input logic [N_HOST-1:0] host_en,
   input logic              host_req
);
   localparam logic [VEC_W-1:0] VEC_MAX = VEC_W'(2 * ((1 << HV_W) - 1));

   AST_REQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> $past(|pend)); // R3
   AST_VEC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> !irq_vec[0]); // R4
   AST_VEC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_vec <= VEC_MAX); // R6
   AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack && !soft_rst) |=> (irq_req && $stable(irq_vec))); // R8
   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> !irq_req); // R8
   AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!irq_req && dsp_flags == 2'b00)); // R9

   if (HOST_REG) begin : g_host_reg
      AST_HOST_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (|(host_stat & host_en)) |=> host_req); // R10
      AST_HOST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(host_stat & host_en)) |=> !host_req); // R10
   end else begin : g_host_comb
      always_comb begin
         if (rst_n) begin
            AST_HOST_COMB: assert (host_req == |(host_stat & host_en)); // R10
         end
      end
   end
endmodule

bind hpi_vec_gen hpi_vec_gen_chk #(
   .HV_W(HV_W), .VEC_W(VEC_W), .N_HOST(N_HOST),
   .NSRC(hpi_vec_pkg::NUM_SRC), .HOST_REG(HOST_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pend(pend),
   .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec),
   .dsp_flags(dsp_flags), .host_stat(host_stat), .host_en(host_en),
   .host_req(host_req)
);

// File: tb/hpi_vec_gen_tb.sv
module hpi_vec_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_sel = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [8:0]  st = '0;
   logic [7:0]  cmd_idx = '0;
   logic        port_sel = 1'b0;
   logic        irq_ack = 1'b0;
   logic        irq_req;
   logic [15:0] irq_vec;
   logic [1:0]  dsp_flags;
   logic [2:0]  host_stat = '0;
   logic [2:0]  host_en = '0;
   logic        host_req;
   int          n_chk = 0;
   int          n_err = 0;

   always #5 clk = ~clk;

   hpi_vec_gen u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .stat_rx_full(st[0]), .stat_tx_empty(st[1]), .stat_mem_req(st[7:2]),
      .stat_cmd_pend(st[8]), .cmd_idx(cmd_idx), .port_sel(port_sel),
      .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec), .dsp_flags(dsp_flags),
      .host_stat(host_stat), .host_en(host_en), .host_req(host_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
      tick();
      reg_we = 1'b0;
   endtask

   function automatic logic [15:0] exp_vec(input logic [8:0] p, input logic prt, input logic [7:0] idx);
      for (int j = 0; j < 8; j++)
         if (p[j]) return 16'((prt ? 'h30 : 'h20) + 2 * j);
      return {7'd0, idx, 1'b0};
   endfunction

   // all enables assumed set
   task automatic pat(input string tag, input logic [8:0] p, input logic prt, input logic [7:0] idx);
      logic [15:0] ev;
      ev = exp_vec(p, prt, idx);
      st = p; port_sel = prt; cmd_idx = idx;
      #1 chk("R3 no request before edge", irq_req, 0);
      @(negedge clk);
      chk("R3 request one clock later", irq_req, |p);
      if (|p) begin
         chk(tag, irq_vec, ev);
         port_sel = ~prt; cmd_idx = ~idx; st = ~p;
         tick();
         chk("R8 request held", irq_req, 1);
         chk("R8 vector held", irq_vec, ev);
         irq_ack = 1'b1; st = '0;
         tick();
         irq_ack = 1'b0;
         chk("R8 ack drops request", irq_req, 0);
      end
      st = '0;
      tick();
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq_req", irq_req, 0);
      chk("R1 host_req", host_req, 0);
      chk("R1 flags", dsp_flags, 0);
      reg_sel = 1'b0; #1 chk("R1 ctl byte", reg_rdata, 0);
      reg_sel = 1'b1; #1 chk("R1 mem byte", reg_rdata, 0);
      @(negedge clk);

      // R2 layout and readback
      wr(1'b0, 8'h08); chk("R2 flag2 bit3", dsp_flags, 2'b01);
      wr(1'b0, 8'h10); chk("R2 flag3 bit4", dsp_flags, 2'b10);
      wr(1'b0, 8'hE5); reg_sel = 1'b0; #1 chk("R2 ctl readback", reg_rdata, 8'hE5);
      @(negedge clk);
      wr(1'b1, 8'hAA); reg_sel = 1'b1; #1 chk("R2 mem readback", reg_rdata, 8'hAA);
      @(negedge clk);
      wr(1'b0, 8'h07);
      wr(1'b1, 8'h3F);

      // R4 / R5: every fixed source on both tables
      for (int prt = 0; prt < 2; prt++)
         for (int k = 0; k < 8; k++)
            pat(prt ? "R5 port B vector" : "R4 port A vector", 9'(1 << k), prt[0], 8'h33);

      // R6: every command index
      for (int i = 0; i < 256; i++)
         pat("R6 command vector", 9'h100, i[0], i[7:0]);

      // R7: every pending combination
      for (int m = 1; m < 512; m++)
         pat("R7 priority", m[8:0], m[3], 8'h5A);

      // R3 / R2: disable each source alone, status held high
      for (int s = 0; s < 9; s++) begin
         if (s == 0)      wr(1'b0, 8'h06);
         else if (s == 1) wr(1'b0, 8'h05);
         else if (s == 8) wr(1'b0, 8'h03);
         else             wr(1'b1, 8'(8'h3F & ~(1 << (s - 2))));
         st = 9'(1 << s);
         tick(); tick();
         chk("R3 disabled source gives no request", irq_req, 0);
         st = '0;
         wr(1'b0, 8'h07);
         wr(1'b1, 8'h3F);
      end

      // R8: ack with a source still pending re-arbitrates
      port_sel = 1'b0;
      st = 9'b11;
      tick();
      chk("R8 first winner", irq_vec, 16'h20);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      chk("R8 dropped after ack", irq_req, 0);
      tick();
      chk("R8 re-armed", irq_req, 1);
      chk("R8 re-armed vector", irq_vec, 16'h20);
      st = 9'b10;
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      tick();
      chk("R8 next source vector", irq_vec, 16'h22);
      st = '0;
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      chk("R8 ack while idle ignored", irq_req, 0);

      // R9 software reset
      wr(1'b0, 8'hFF);
      wr(1'b1, 8'hFF);
      st = 9'b1;
      tick();
      chk("R9 armed before soft reset", irq_req, 1);
      soft_rst = 1'b1; tick(); soft_rst = 1'b0;
      chk("R9 request cleared", irq_req, 0);
      chk("R9 flags cleared", dsp_flags, 0);
      reg_sel = 1'b0; #1 chk("R9 ctl cleared", reg_rdata, 0);
      reg_sel = 1'b1; #1 chk("R9 mem cleared", reg_rdata, 0);
      @(negedge clk);
      tick();
      chk("R9 enables cleared, no request", irq_req, 0);
      st = '0;

      // R10 host side sweep
      for (int c = 0; c < 64; c++) begin
         host_stat = c[2:0]; host_en = c[5:3];
         tick();
         chk("R10 host request", host_req, |(c[2:0] & c[5:3]));
      end
      report();
   end
endmodule